// File: doc/BRIEF.md
# Burn-in Sync and Test Pattern Generator

This block produces free-running horizontal and vertical sync from an 8 MHz clock. A monitor can then run burn-in with no video source attached. A self-mode input picks what drives the HSO and VSO outputs. When it is set, they carry the generated timing. When it is clear, they carry the processed sync inputs unchanged.

A two-bit code picks one of three timing sets:

- 64 kHz lines at 62.5 Hz frames.
- About 47.9 kHz lines at 74.9 Hz frames.
- About 31.1 kHz lines at 60.8 Hz frames.

A change to the code is held back until the current frame ends, so no short pulse reaches the outputs.

The same raster counters feed a one-bit test pattern. It can be a cross hatch, the inverse of the hatch, all white or all black. The pattern appears only while the pattern enable is set. The enable is also brought out so that the pin can be released to general-purpose use.

Top module: `burnin_sync_gen`

## Requirements
- R1: While `self_en` is 0, `hso` equals `hs_in` and `vso` equals `vs_in` in the same cycle.
- R2: With `sel_48k`=0 and `sel_64k`=1, a line lasts 125 clocks and a frame lasts 1024 lines.
- R3: With `sel_48k`=1, a line lasts 167 clocks and a frame lasts 640 lines, for either value of `sel_64k`.
- R4: With both select bits 0, a line lasts 257 clocks and a frame lasts 512 lines. After reset the generator starts in this set, at line 0 and clock 0.
- R5: The generated horizontal pulse is high for the first 8 clocks of each line. The generated vertical pulse is high for the first 3 lines of each frame.
- R6: `pat_sel` selects the pattern: 2'b00 gives the hatch, 2'b01 gives constant 1, 2'b10 gives the inverted hatch, and 2'b11 gives constant 0.
- R7: `pat_oe` follows `pat_en`. While `pat_en` is 0, `pat_out` is 0.
- R8: The hatch is 1 when the clock index within the line is a multiple of 16, or when the line index is a multiple of 32.
- R9: A change of the select bits takes effect only at the first clock of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_en | input | 1 | 1 selects generated sync on the outputs |
| sel_64k | input | 1 | Timing select bit, picks the 64 kHz set when `sel_48k` is 0 |
| sel_48k | input | 1 | Timing select bit, picks the 47.9 kHz set |
| hs_in | input | 1 | Processed horizontal sync for pass-through |
| vs_in | input | 1 | Processed vertical sync for pass-through |
| pat_en | input | 1 | Test pattern enable |
| pat_sel | input | 2 | Pattern code |
| hso | output | 1 | Horizontal sync out |
| vso | output | 1 | Vertical sync out |
| pat_out | output | 1 | Test pattern bit |
| pat_oe | output | 1 | Pattern output drive enable |

## Verification
The outputs are combinational functions of the raster counters and the inputs. A change to `self_en`, `pat_en`, `pat_sel`, `hs_in` or `vs_in` therefore shows up in the same cycle. Counter-driven values move one clock edge after the edge that advances the counters. A select change appears only at the first clock of the following frame.

The bench drives inputs on the falling edge. It advances a behavioural raster model on the rising edge and compares every output 1 ns after each falling edge, so each result is read once all of its registers have settled. Line lengths and frame lengths are also measured directly from the edges of `hso` and `vso`. These measurements include a line taken after a mid-frame select change, which must still show the old timing.

// File: rtl/burnin_sync_gen.sv
module burnin_sync_gen #(
  parameter int H_PER_64   = 125,
  parameter int H_PER_48   = 167,
  parameter int H_PER_31   = 257,
  parameter int LINES_64   = 1024,
  parameter int LINES_48   = 640,
  parameter int LINES_31   = 512,
  parameter int HS_CLKS    = 8,
  parameter int VS_LINES   = 3,
  parameter int HATCH_X    = 16,
  parameter int HATCH_Y    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       self_en,
  input  logic       sel_64k,
  input  logic       sel_48k,
  input  logic       hs_in,
  input  logic       vs_in,
  input  logic       pat_en,
  input  logic [1:0] pat_sel,
  output logic       hso,
  output logic       vso,
  output logic       pat_out,
  output logic       pat_oe
);
  localparam int H_MAX = (H_PER_31 > H_PER_48) ?
                         ((H_PER_31 > H_PER_64) ? H_PER_31 : H_PER_64) :
                         ((H_PER_48 > H_PER_64) ? H_PER_48 : H_PER_64);
  localparam int V_MAX = (LINES_31 > LINES_48) ?
                         ((LINES_31 > LINES_64) ? LINES_31 : LINES_64) :
                         ((LINES_48 > LINES_64) ? LINES_48 : LINES_64);
  localparam int HW = $clog2(H_MAX);
  localparam int VW = $clog2(V_MAX);
  localparam logic [1:0] M31 = 2'd0, M48 = 2'd1, M64 = 2'd2;

  logic [HW-1:0] hcnt, h_last;
  logic [VW-1:0] vcnt, v_last;
  logic [1:0]    mode, next_mode;
  logic          line_end, frame_end, gen_hs, gen_vs, hatch, pat_bit;

  assign next_mode = sel_48k ? M48 : (sel_64k ? M64 : M31);

  always_comb begin
    case (mode)
      M64:     begin h_last = HW'(H_PER_64 - 1); v_last = VW'(LINES_64 - 1); end
      M48:     begin h_last = HW'(H_PER_48 - 1); v_last = VW'(LINES_48 - 1); end
      default: begin h_last = HW'(H_PER_31 - 1); v_last = VW'(LINES_31 - 1); end
    endcase
  end

  assign line_end  = (hcnt == h_last);
  assign frame_end = line_end && (vcnt == v_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      mode <= M31;
    end else if (line_end) begin
      hcnt <= '0;
      if (frame_end) begin
        vcnt <= '0;
        mode <= next_mode;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign gen_hs = (hcnt < HW'(HS_CLKS));
  assign gen_vs = (vcnt < VW'(VS_LINES));
  assign hatch  = ((hcnt % HW'(HATCH_X)) == '0) || ((vcnt % VW'(HATCH_Y)) == '0);

  always_comb begin
    case (pat_sel)
      2'b00:   pat_bit = hatch;
      2'b01:   pat_bit = 1'b1;
      2'b10:   pat_bit = ~hatch;
      default: pat_bit = 1'b0;
    endcase
  end

  assign hso     = self_en ? gen_hs : hs_in;
  assign vso     = self_en ? gen_vs : vs_in;
  assign pat_oe  = pat_en;
  assign pat_out = pat_en & pat_bit;
endmodule

module burnin_sync_chk #(
  parameter int HW = 9,
  parameter int VW = 10,
  parameter int VS_LINES = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          self_en,
  input logic          pat_en,
  input logic [1:0]    pat_sel,
  input logic          vso,
  input logic          pat_out,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic [HW-1:0] h_last,
  input logic [1:0]    mode
);
  p_mode_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> (hcnt == '0 && vcnt == '0));
  p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != $past(vcnt)) |-> (hcnt == '0));
  p_hcnt_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= h_last);
  p_vs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (self_en && vso) |-> (vcnt < VW'(VS_LINES)));
  p_white_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && pat_sel == 2'b01) |-> pat_out);
  p_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == 2'b11) |-> !pat_out);
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_en |-> !pat_out);
endmodule

bind burnin_sync_gen burnin_sync_chk #(.HW(HW), .VW(VW), .VS_LINES(VS_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .self_en(self_en), .pat_en(pat_en), .pat_sel(pat_sel),
  .vso(vso), .pat_out(pat_out), .hcnt(hcnt), .vcnt(vcnt), .h_last(h_last), .mode(mode)
);

// File: tb/burnin_sync_gen_tb.sv
module burnin_sync_gen_tb;
  localparam int HP64 = 125, HP48 = 167, HP31 = 257;
  localparam int L64 = 16, L48 = 12, L31 = 8;
  localparam int HSW = 8, VSL = 3, HX = 16, HY = 4;

  logic clk = 0, rst_n = 0, self_en = 1, sel_64k = 0, sel_48k = 0;
  logic hs_in = 0, vs_in = 0, pat_en = 1;
  logic [1:0] pat_sel = 2'b00;
  logic hso, vso, pat_out, pat_oe;
  int checks = 0, fails = 0;
  int mh = 0, mv = 0, mmode = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burnin_sync_gen #(.H_PER_64(HP64), .H_PER_48(HP48), .H_PER_31(HP31),
    .LINES_64(L64), .LINES_48(L48), .LINES_31(L31), .HS_CLKS(HSW),
    .VS_LINES(VSL), .HATCH_X(HX), .HATCH_Y(HY)) u_dut (
    .clk(clk), .rst_n(rst_n), .self_en(self_en), .sel_64k(sel_64k), .sel_48k(sel_48k),
    .hs_in(hs_in), .vs_in(vs_in), .pat_en(pat_en), .pat_sel(pat_sel),
    .hso(hso), .vso(vso), .pat_out(pat_out), .pat_oe(pat_oe));

  function automatic int per(int m); return m == 2 ? HP64 : (m == 1 ? HP48 : HP31); endfunction
  function automatic int lns(int m); return m == 2 ? L64 : (m == 1 ? L48 : L31); endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mmode = 0;
    end else if (mh == per(mmode) - 1) begin
      mh = 0;
      if (mv == lns(mmode) - 1) begin
        mv = 0;
        mmode = sel_48k ? 1 : (sel_64k ? 2 : 0);
      end else mv++;
    end else mh++;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit hatch, pb;
      hatch = (mh % HX == 0) || (mv % HY == 0);
      case (pat_sel)
        2'b00: pb = hatch;
        2'b01: pb = 1;
        2'b10: pb = !hatch;
        default: pb = 0;
      endcase
      chk(self_en ? "R5 hso" : "R1 hso", hso, self_en ? (mh < HSW) : hs_in);
      chk(self_en ? "R5 vso" : "R1 vso", vso, self_en ? (mv < VSL) : vs_in);
      chk(pat_en ? "R6/R8 pat_out" : "R7 pat_out", pat_out, pat_en & pb);
      chk("R7 pat_oe", pat_oe, pat_en);
    end
  end

  task automatic measure(input int exp_h, input int exp_l, input string tag);
    int cyc, first, lines;
    bit ph, pv;
    ph = 1; pv = 1;
    do begin @(negedge clk); #1; pv = vso; end while (!(vso && !pv) && 0);
    pv = vso;
    forever begin
      @(negedge clk); #1;
      if (vso && !pv) break;
      pv = vso;
    end
    cyc = 0; first = -1; lines = 1; ph = 1; pv = 1;
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (hso && !ph) begin
        if (first < 0) first = cyc;
        lines++;
      end
      if (vso && !pv) break;
      ph = hso; pv = vso;
    end
    chk({tag, " line period"}, first, exp_h);
    chk({tag, " lines per frame"}, lines - 1, exp_l);
  endtask

  task automatic one_line(input int exp_h, input string tag);
    int cyc;
    bit ph;
    ph = hso;
    forever begin @(negedge clk); #1; if (hso && !ph) break; ph = hso; end
    cyc = 0; ph = 1;
    forever begin @(negedge clk); #1; cyc++; if (hso && !ph) break; ph = hso; end
    chk(tag, cyc, exp_h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R4 reset hso", hso, 1);
    chk("R4 reset vso", vso, 1);
    chk("R8 reset hatch", pat_out, 1);
    @(negedge clk);
    rst_n = 1;
    measure(HP31, L31, "R4");
    sel_64k = 1;
    one_line(HP31, "R9 old timing kept mid-frame");
    measure(HP64, L64, "R2");
    sel_48k = 1;
    measure(HP48, L48, "R3 both set");
    sel_64k = 0;
    measure(HP48, L48, "R3 48k only");
    sel_48k = 0;
    measure(HP31, L31, "R4 back");
    for (int s = 0; s < 4; s++) begin
      pat_sel = 2'(s);
      repeat (300) @(negedge clk);
    end
    pat_en = 0;
    repeat (200) @(negedge clk);
    pat_en = 1; pat_sel = 2'b10;
    self_en = 0;
    for (int i = 0; i < 60; i++) begin
      hs_in = (i % 3 == 0); vs_in = (i % 7 < 2);
      @(negedge clk);
    end
    self_en = 1;
    repeat (20) @(negedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule